// File: doc/BRIEF.md
# Hex-to-Segment Serial Display Driver

This block is the host-side controller for a four-digit seven-segment display module fed over three wires: a serial clock, a serial data line and a load strobe. On a start strobe it takes a 16-bit value as four hexadecimal digits, plus one decimal-point enable per digit. It turns each digit into a seven-segment pattern, shifts the resulting 32-bit frame out one bit per serial clock period and then pulses load. The receiver copies its shift register to the display latches while load is high.

The receiver captures data on each falling edge of the serial clock. The driver therefore changes data only on rising edges, which leaves half a serial period of set-up and of hold around every capture. The serial half-period and the load width are derived at elaboration from the system clock frequency, the target serial rate and the minimum load width. A one-cycle done pulse follows the load pulse. A start request that arrives during a transfer is dropped.

Top module: `hex_serial_display_drv`

## Requirements
- R1: Each nibble maps to segments {g,f,e,d,c,b,a} as 0=3F, 1=06, 2=5B, 3=4F, 4=66, 5=6D, 6=7D, 7=07, 8=7F, 9=6F, A=77, B=7C, C=39, D=5E, E=79, F=71 (hex, bit 0 = segment a), and a segment is lit by a 1.
- R2: Each transfer sends exactly 32 bits. Digits go out in the order 1,2,3,4, where digit n uses value_i[4n-1:4n-4] and dp_i[n-1]. Within a digit the order is DP, E, D, C, B, A, F, G, so the first bit is the DP of digit 1 and the last is segment G of digit 4.
- R3: While a transfer runs, ser_data_o changes only in the cycle where ser_clk_o rises. It is stable for the whole low phase, and the first bit is presented while ser_clk_o is high, before the first falling edge.
- R4: Every high phase before a falling edge and every low phase of ser_clk_o lasts exactly HALF_CYC = ceil(CLK_MHZ*1000/(2*SCLK_KHZ)) system cycles (67 with the defaults). This keeps the serial rate at or below SCLK_KHZ with a 50% duty cycle.
- R5: ser_load_o rises only after the 32nd falling edge, with ser_clk_o back high. It stays high for exactly LOAD_CYC = ceil(LOAD_NS*CLK_MHZ/1000) cycles (35 with the defaults).
- R6: done_o is high for exactly one cycle, the cycle after ser_load_o falls. busy_o is high from the cycle after an accepted start through the done cycle.
- R7: A start_i seen while busy_o is high is ignored: it neither restarts nor queues a transfer.
- R8: In reset and when idle, ser_clk_o is high and ser_load_o, busy_o and done_o are low. A reset in mid-transfer returns the block to this state.
- R9: value_i and dp_i are sampled only in the cycle a start is accepted. Later changes do not alter the frame being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a transfer when idle |
| value_i | input | 16 | Four hex digits, digit 1 in bits [3:0] |
| dp_i | input | 4 | Decimal-point enables, bit n-1 for digit n |
| ser_clk_o | output | 1 | Serial clock, idles high |
| ser_data_o | output | 1 | Serial data, changes on rising ser_clk_o |
| ser_load_o | output | 1 | Latch strobe to the display, active high |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle pulse at the end of a transfer |

## Verification
The bench models the receiver. It shifts in ser_data_o on every falling edge and snapshots the word when load rises, so a swapped digit or segment order, a wrong glyph or an off-by-one bit count shows up as a frame mismatch or a bit count other than 32. It times every serial phase and the load width in cycles, which catches an off-by-one timer that would give a short phase or a narrow load. It also flags any data change outside a rising edge, which catches data updated at the capture edge. A start pulse and new input values injected mid-transfer, followed by a quiet window, catch a design that restarts, queues the request or samples its inputs late. A reset in mid-transfer checks that the idle levels return at once.

// File: rtl/hsd_pkg.sv
package hsd_pkg;
  typedef struct packed {
    logic g, f, e, d, c, b, a;
  } seg7_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_HI, ST_LO, ST_LOAD, ST_DONE
  } tx_state_e;
endpackage

// File: rtl/hsd_hex7.sv
module hsd_hex7
  import hsd_pkg::*;
(
  input  logic [3:0] nib_i,
  output seg7_t      seg_o
);
  always_comb begin
    unique case (nib_i)
      4'h0: seg_o = 7'h3F;
      4'h1: seg_o = 7'h06;
      4'h2: seg_o = 7'h5B;
      4'h3: seg_o = 7'h4F;
      4'h4: seg_o = 7'h66;
      4'h5: seg_o = 7'h6D;
      4'h6: seg_o = 7'h7D;
      4'h7: seg_o = 7'h07;
      4'h8: seg_o = 7'h7F;
      4'h9: seg_o = 7'h6F;
      4'hA: seg_o = 7'h77;
      4'hB: seg_o = 7'h7C;
      4'hC: seg_o = 7'h39;
      4'hD: seg_o = 7'h5E;
      4'hE: seg_o = 7'h79;
      default: seg_o = 7'h71;
    endcase
  end
endmodule

// File: rtl/hsd_frame_pack.sv
module hsd_frame_pack
  import hsd_pkg::*;
#(
  parameter int NUM_DIGITS = 4,
  localparam int FRAME_BITS = 8 * NUM_DIGITS
) (
  input  logic [4*NUM_DIGITS-1:0] value_i,
  input  logic [NUM_DIGITS-1:0]   dp_i,
  output logic [FRAME_BITS-1:0]   frame_o
);
  seg7_t seg [NUM_DIGITS];

  // digit 0 lands in the top byte so it leaves first; per-digit order DP,E,D,C,B,A,F,G
  for (genvar gd = 0; gd < NUM_DIGITS; gd++) begin : g_digit
    hsd_hex7 u_hex7 (
      .nib_i (value_i[4*gd +: 4]),
      .seg_o (seg[gd])
    );
    assign frame_o[FRAME_BITS-1-8*gd -: 8] = {dp_i[gd], seg[gd].e, seg[gd].d, seg[gd].c,
                                              seg[gd].b, seg[gd].a, seg[gd].f, seg[gd].g};
  end
endmodule

// File: rtl/hsd_ser_tx.sv
module hsd_ser_tx
  import hsd_pkg::*;
#(
  parameter int FRAME_BITS = 32,
  parameter int HALF_CYC   = 67,
  parameter int LOAD_CYC   = 35
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  start_i,
  input  logic [FRAME_BITS-1:0] frame_i,
  output logic                  ser_clk_o,
  output logic                  ser_data_o,
  output logic                  ser_load_o,
  output logic                  busy_o,
  output logic                  done_o
);
  localparam int MAX_CYC = (HALF_CYC > LOAD_CYC) ? HALF_CYC : LOAD_CYC;
  localparam int TW      = $clog2(MAX_CYC + 1);
  localparam int CW      = $clog2(FRAME_BITS);
  localparam logic [TW-1:0] HALF_M1 = TW'(HALF_CYC - 1);
  localparam logic [TW-1:0] LOAD_M1 = TW'(LOAD_CYC - 1);
  localparam logic [CW-1:0] LAST_BIT = CW'(FRAME_BITS - 1);

  tx_state_e             state_q;
  logic [TW-1:0]         tmr_q;
  logic [CW-1:0]         bit_q;
  logic [FRAME_BITS-1:0] shift_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      tmr_q   <= '0;
      bit_q   <= '0;
      shift_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          shift_q <= frame_i;
          bit_q   <= '0;
          tmr_q   <= HALF_M1;
          state_q <= ST_HI;
        end
        ST_HI: if (tmr_q == '0) begin
          tmr_q   <= HALF_M1;
          state_q <= ST_LO;
        end else tmr_q <= tmr_q - 1'b1;
        ST_LO: if (tmr_q == '0) begin
          if (bit_q == LAST_BIT) begin
            tmr_q   <= LOAD_M1;
            state_q <= ST_LOAD;
          end else begin
            // rising edge: advance data
            shift_q <= {shift_q[FRAME_BITS-2:0], 1'b0};
            bit_q   <= bit_q + 1'b1;
            tmr_q   <= HALF_M1;
            state_q <= ST_HI;
          end
        end else tmr_q <= tmr_q - 1'b1;
        ST_LOAD: if (tmr_q == '0) state_q <= ST_DONE;
                 else tmr_q <= tmr_q - 1'b1;
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign ser_clk_o  = (state_q != ST_LO);
  assign ser_data_o = shift_q[FRAME_BITS-1];
  assign ser_load_o = (state_q == ST_LOAD);
  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = (state_q == ST_DONE);
endmodule

// File: rtl/hex_serial_display_drv.sv
module hex_serial_display_drv #(
  parameter int NUM_DIGITS = 4,
  parameter int CLK_MHZ    = 200,
  parameter int SCLK_KHZ   = 1500,
  parameter int LOAD_NS    = 175
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_i,
  input  logic [4*NUM_DIGITS-1:0] value_i,
  input  logic [NUM_DIGITS-1:0]   dp_i,
  output logic                    ser_clk_o,
  output logic                    ser_data_o,
  output logic                    ser_load_o,
  output logic                    busy_o,
  output logic                    done_o
);
  localparam int FRAME_BITS = 8 * NUM_DIGITS;
  localparam int HALF_CYC   = (CLK_MHZ * 1000 + 2 * SCLK_KHZ - 1) / (2 * SCLK_KHZ);
  localparam int LOAD_CYC   = (LOAD_NS * CLK_MHZ + 999) / 1000;

  logic [FRAME_BITS-1:0] frame;

  hsd_frame_pack #(.NUM_DIGITS(NUM_DIGITS)) u_pack (
    .value_i (value_i),
    .dp_i    (dp_i),
    .frame_o (frame)
  );

  hsd_ser_tx #(
    .FRAME_BITS (FRAME_BITS),
    .HALF_CYC   (HALF_CYC),
    .LOAD_CYC   (LOAD_CYC)
  ) u_tx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .frame_i    (frame),
    .ser_clk_o  (ser_clk_o),
    .ser_data_o (ser_data_o),
    .ser_load_o (ser_load_o),
    .busy_o     (busy_o),
    .done_o     (done_o)
  );
endmodule

// File: rtl/hsd_checker.sv
module hsd_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic ser_clk_o,
  input logic ser_data_o,
  input logic ser_load_o,
  input logic busy_o,
  input logic done_o
);
  assert_data_stable_low_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ser_clk_o && $past(!ser_clk_o)) |-> $stable(ser_data_o));

  assert_load_clk_high_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ser_load_o |-> ser_clk_o);

  assert_done_after_load_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($past(ser_load_o) && !ser_load_o));

  assert_done_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_start_accept_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i));

  assert_no_restart_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o) |=> busy_o);

  assert_idle_levels_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (ser_clk_o && !ser_load_o && !done_o));
endmodule

bind hex_serial_display_drv hsd_checker u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .ser_clk_o  (ser_clk_o),
  .ser_data_o (ser_data_o),
  .ser_load_o (ser_load_o),
  .busy_o     (busy_o),
  .done_o     (done_o)
);

// File: tb/hex_serial_display_drv_tb_top.sv
`timescale 1ns/1ps
module hex_serial_display_drv_tb_top;
  localparam int CLK_MHZ  = 200;
  localparam int SCLK_KHZ = 1500;
  localparam int LOAD_NS  = 175;
  localparam int HALF     = (CLK_MHZ * 1000 + 2 * SCLK_KHZ - 1) / (2 * SCLK_KHZ);
  localparam int LOADW    = (LOAD_NS * CLK_MHZ + 999) / 1000;
  localparam int NVEC     = 6;
  // {dp[3:0], value[15:0]}
  localparam logic [19:0] VEC [NVEC] = '{
    {4'b0000, 16'h3210}, {4'b1111, 16'h7654}, {4'b0101, 16'hBA98},
    {4'b1010, 16'hFEDC}, {4'b0001, 16'hFFFF}, {4'b1000, 16'h0000}
  };

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [15:0] value = '0;
  logic [3:0]  dp = '0;
  logic sclk, sdata, sload, busy, done;

  int checks = 0, fails = 0, cyc = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  hex_serial_display_drv dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .value_i(value), .dp_i(dp),
    .ser_clk_o(sclk), .ser_data_o(sdata), .ser_load_o(sload), .busy_o(busy), .done_o(done)
  );

  function automatic logic [6:0] seg_of(input logic [3:0] n);
    case (n)
      4'h0: return 7'h3F; 4'h1: return 7'h06; 4'h2: return 7'h5B; 4'h3: return 7'h4F;
      4'h4: return 7'h66; 4'h5: return 7'h6D; 4'h6: return 7'h7D; 4'h7: return 7'h07;
      4'h8: return 7'h7F; 4'h9: return 7'h6F; 4'hA: return 7'h77; 4'hB: return 7'h7C;
      4'hC: return 7'h39; 4'hD: return 7'h5E; 4'hE: return 7'h79; default: return 7'h71;
    endcase
  endfunction

  function automatic logic [31:0] exp_frame(input logic [15:0] v, input logic [3:0] d);
    logic [31:0] f = '0;
    for (int i = 0; i < 4; i++) begin
      logic [6:0] s = seg_of(v[4*i +: 4]);
      f = {f[23:0], d[i], s[4], s[3], s[2], s[1], s[0], s[5], s[6]};
    end
    return f;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // receiver model and timing monitor
  logic p_sclk = 1, p_sdata = 0, p_load = 0, p_busy = 0;
  logic [31:0] rx_word = '0, ld_word = '0;
  int rx_bits = 0, ld_bits = 0, ld_w = 0, ld_width = 0;
  int hi_run = 0, lo_run = 0, tim_err = 0, dat_err = 0, done_cnt = 0, done_bad = 0;

  always @(negedge clk) begin
    if (!rst_n) begin
      p_sclk = 1; p_load = 0; p_busy = 0; p_sdata = sdata;
    end else begin
      if (busy && !p_busy) begin rx_bits = 0; hi_run = 0; lo_run = 0; end
      if (p_sclk && !sclk) begin
        rx_word = {rx_word[30:0], sdata};
        rx_bits++;
        if (hi_run != HALF) tim_err++;
        lo_run = 0;
      end
      if (!p_sclk && sclk) begin
        if (lo_run != HALF) tim_err++;
        hi_run = 0;
      end
      if (busy && p_busy && (sdata != p_sdata) && !(sclk && !p_sclk)) dat_err++;
      if (sload && !p_load) begin ld_bits = rx_bits; ld_word = rx_word; ld_w = 0; end
      if (sload) ld_w++;
      if (!sload && p_load) ld_width = ld_w;
      if (done) begin
        done_cnt++;
        if (!p_load || sload) done_bad++;
      end
      if (busy) begin
        if (!sclk) lo_run++;
        else if (!sload && !done) hi_run++;
      end
      p_sclk = sclk; p_sdata = sdata; p_load = sload; p_busy = busy;
    end
  end

  task automatic kick(input logic [15:0] v, input logic [3:0] d);
    @(negedge clk);
    while (busy) @(negedge clk);
    value = v; dp = d; start = 1;
    @(negedge clk);
    start = 0;
    chk(busy === 1'b1, "R6 busy after start", {31'd0, busy}, 32'd1);
  endtask

  task automatic wait_done();
    while (!done) @(negedge clk);
    @(negedge clk);
    chk(done === 1'b0, "R6 done one cycle", {31'd0, done}, 32'd0);
  endtask

  task automatic check_frame(input logic [31:0] exp, input int done_before);
    chk(ld_bits == 32, "R2 bit count at load", ld_bits, 32);
    chk(ld_word == exp, "R1/R2 frame content", ld_word, exp);
    chk(tim_err == 0, "R4 phase timing errors", tim_err, 0);
    chk(dat_err == 0, "R3 data change off rising edge", dat_err, 0);
    chk(ld_width == LOADW, "R5 load width", ld_width, LOADW);
    chk(done_cnt == done_before + 1 && done_bad == 0, "R6 done after load",
        done_cnt - done_before, 1);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected < 150000 cycles", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8 reset state
    chk(sclk === 1'b1 && sload === 1'b0 && busy === 1'b0 && done === 1'b0, "R8 reset levels",
        {28'd0, sclk, sload, busy, done}, 32'h8);
    rst_n = 1;
    repeat (3) @(negedge clk);

    for (int i = 0; i < NVEC; i++) begin
      int db;
      tim_err = 0; dat_err = 0;
      db = done_cnt;
      kick(VEC[i][15:0], VEC[i][19:16]);
      wait_done();
      check_frame(exp_frame(VEC[i][15:0], VEC[i][19:16]), db);
    end

    // R7/R9: start and input changes mid-transfer are ignored
    begin
      int db;
      tim_err = 0; dat_err = 0;
      db = done_cnt;
      kick(16'h1E2D, 4'b0110);
      repeat (500) @(negedge clk);
      value = 16'hAAAA; dp = 4'b1001; start = 1;
      @(negedge clk);
      start = 0;
      repeat (300) @(negedge clk);
      value = 16'h5555; dp = 4'b0000;
      wait_done();
      check_frame(exp_frame(16'h1E2D, 4'b0110), db);
      repeat (50) @(negedge clk);
      chk(busy === 1'b0 && done_cnt == db + 1, "R7 no queued transfer",
          {31'd0, busy}, 32'd0);
    end

    // R8: reset in mid-transfer
    kick(16'h4321, 4'b1111);
    repeat (1000) @(negedge clk);
    rst_n = 0;
    @(negedge clk);
    chk(sclk === 1'b1 && sload === 1'b0 && busy === 1'b0 && done === 1'b0, "R8 reset mid-transfer",
        {28'd0, sclk, sload, busy, done}, 32'h8);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk(busy === 1'b0 && sclk === 1'b1, "R8 idle after reset", {30'd0, busy, sclk}, 32'h1);
    begin
      int db;
      tim_err = 0; dat_err = 0;
      db = done_cnt;
      kick(16'h9C5A, 4'b0011);
      wait_done();
      check_frame(exp_frame(16'h9C5A, 4'b0011), db);
    end

    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule